// File: doc/BRIEF.md
# Polyphase Matched-Filter Resampler Bank

This block computes one output sample of an arbitrary-ratio resampler from a complex (I/Q) input stream. It holds two sets of polyphase subfilters: a matched-filter set and a derivative-of-matched-filter set. Both sets are addressed by the same phase index. Input samples are written into a circular delay line, and coefficients are loaded into an internal memory through a write port.

On each request the caller supplies a phase index and an unsigned fraction. The block runs a multiply-accumulate loop over the taps of the selected subfilter in all four lanes: filter×I, filter×Q, derivative×I and derivative×Q. It then returns three things:
- the matched-filter output;
- the derivative output, for use by an external timing-error detector;
- a slope-corrected sample, equal to the filter output plus the fraction times the derivative output.

The phase and fraction come from an external timing loop, which is not part of this block.

Top module: `pfb_resampler`

## Requirements
- R1: While and after reset, `busy` and `out_valid` are 0 and all six data outputs are 0.
- R2: A request is accepted on a clock edge where `busy` is 0 and `req_valid` is 1. `busy` is 1 from that edge on. Exactly NTAP+2 edges after the accepting edge, `out_valid` pulses high for one cycle, and in that same cycle `busy` returns to 0.
- R3: `mf_i` = rs(Σk h[p·NTAP+k]·xI[n−k]) for k = 0..NTAP−1, where p is the requested phase and xI[n] is the most recently written sample. rs(v) = (v + 2^14) >> 15, an arithmetic shift, saturated to 16 bits. Coefficients are Q1.15 and samples are signed 16-bit.
- R4: `dmf_i` and `dmf_q` follow the same formula as R3, using the derivative coefficients d[p·NTAP+k].
- R5: `ip_i` = rs(AH + floor(f·AD / 2^16)). Here AH and AD are the unrounded filter and derivative sums of that lane, and f is `req_frac`, read as unsigned (f/65536 lies in [0,1)). When f = 0, `ip` equals `mf`.
- R6: The I and Q lanes use the same coefficients and are computed independently from the I and Q halves of each stored sample.
- R7: A coefficient write with `coef_we` = 1 and `busy` = 0 stores `coef_h`/`coef_d` at address phase·NTAP+tap. A coefficient write while `busy` = 1 is ignored.
- R8: A sample write with `busy` = 0 appends the sample to the delay line as the newest entry. A sample write while `busy` = 1 is ignored and does not move the delay line.
- R9: `req_valid` while `busy` = 1 is ignored: no extra `out_valid` pulse results from it.
- R10: Results above 32767 saturate to 32767, and results below −32768 saturate to −32768, in every output.
- R11: Different phase indices select disjoint coefficient groups, so each phase produces its own result.
- R12: Once more samples have been written than the delay line holds, only the newest NTAP samples affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_we | input | 1 | Sample write strobe |
| smp_i | input | 16 | Sample, in-phase |
| smp_q | input | 16 | Sample, quadrature |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 11 | Coefficient address, phase·NTAP+tap |
| coef_h | input | 16 | Matched-filter coefficient |
| coef_d | input | 16 | Derivative coefficient |
| req_valid | input | 1 | Output request |
| req_phase | input | 5 | Subfilter index |
| req_frac | input | 16 | Unsigned fraction for slope correction |
| busy | output | 1 | Computation in progress |
| out_valid | output | 1 | One-cycle result strobe |
| mf_i | output | 16 | Matched-filter output, I |
| mf_q | output | 16 | Matched-filter output, Q |
| dmf_i | output | 16 | Derivative output, I |
| dmf_q | output | 16 | Derivative output, Q |
| ip_i | output | 16 | Slope-corrected output, I |
| ip_q | output | 16 | Slope-corrected output, Q |

## Verification
An impulse with different values on I and Q exposes a single coefficient per lane. It separates a swapped lane, a wrong tap order or a wrong derivative bank from correct behaviour. Pseudo-random samples run through phases 0, 17 and 31 with fractions of one half, just under one and an odd value. These exercise phase addressing and the slope term, including its floor rounding. A load of full-scale coefficients and samples with opposite signs on the two lanes drives both saturation limits. A burst longer than the delay line checks that the read window follows the write pointer across the wrap. Writes and a request issued mid-computation show, through a repeat request, whether any of them leaked into the stored state.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } pfb_state_e;
endpackage

// File: rtl/pfb_delay_line.sv
// Circular sample store: one write port for incoming samples, one
// registered read port addressed relative to the newest entry.
module pfb_delay_line #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int TW    = 6,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic signed [DW-1:0] wi,
  input  logic signed [DW-1:0] wq,
  input  logic                 rd_en,
  input  logic [TW-1:0]        age,
  output logic signed [DW-1:0] rdi,
  output logic signed [DW-1:0] rdq,
  output logic [PW-1:0]        wptr
);
  logic [2*DW-1:0] mem [DEPTH];
  logic [PW-1:0]   ra;
  logic [2*DW-1:0] rword;

  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= {wi, wq};
  end

  always_ff @(posedge clk) begin
    if (rst)     wptr <= '0;
    else if (we) wptr <= wptr + 1'b1;
  end

  // newest entry sits one below the write pointer
  assign ra = wptr - PW'(1) - PW'(age);

  always_ff @(posedge clk) begin
    if (rd_en) rword <= mem[ra];
  end

  assign rdi = rword[2*DW-1:DW];
  assign rdq = rword[DW-1:0];
endmodule

// File: rtl/pfb_coef_bank.sv
// Coefficient memory holding both filter and derivative banks side by side.
module pfb_coef_bank #(
  parameter int CW    = 16,
  parameter int NCOEF = 1248,
  localparam int AW   = $clog2(NCOEF)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [CW-1:0] wh,
  input  logic signed [CW-1:0] wd,
  input  logic                 rd_en,
  input  logic [AW-1:0]        raddr,
  output logic signed [CW-1:0] rh,
  output logic signed [CW-1:0] rd
);
  logic [2*CW-1:0] mem [NCOEF];
  logic [2*CW-1:0] rword;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wh, wd};
  end

  always_ff @(posedge clk) begin
    if (rd_en) rword <= mem[raddr];
  end

  assign rh = rword[2*CW-1:CW];
  assign rd = rword[CW-1:0];
endmodule

// File: rtl/pfb_ctrl.sv
// Sequencer: accepts a request, walks the taps of the chosen phase,
// waits for the read and accumulate stages, then strobes the result stage.
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int NPHASE = 32,
  parameter int NTAP   = 39,
  localparam int PHW   = $clog2(NPHASE),
  localparam int TW    = $clog2(NTAP),
  localparam int CAW   = $clog2(NPHASE * NTAP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [PHW-1:0] req_phase,
  output logic           busy,
  output logic           accept,
  output logic           rd_en,
  output logic [TW-1:0]  tap,
  output logic [CAW-1:0] caddr,
  output logic           fin
);
  pfb_state_e     state;
  logic [CAW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tap   <= '0;
      base  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            base  <= CAW'(req_phase) * CAW'(NTAP);
            tap   <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tap == TW'(NTAP - 1)) state <= ST_DRAIN;
          else                      tap   <= tap + 1'b1;
        end
        ST_DRAIN: state <= ST_FIN;
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && req_valid;
  assign rd_en  = (state == ST_RUN);
  assign fin    = (state == ST_FIN);
  assign caddr  = base + CAW'(tap);
endmodule

// File: rtl/pfb_mac.sv
// Four MAC lanes (filter/derivative x I/Q) plus the rounding, slope
// correction and saturation stage.
module pfb_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 40,
  parameter int FW   = 16,
  localparam int XW  = ACCW + 2,
  localparam int PWW = DW + CW,
  localparam int SPW = ACCW + FW + 1,
  localparam int SH  = CW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [FW-1:0]        frac_in,
  input  logic                 rd_en,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] xq,
  input  logic signed [CW-1:0] ch,
  input  logic signed [CW-1:0] cd,
  input  logic                 fin,
  output logic                 out_valid,
  output logic signed [DW-1:0] mf_i,
  output logic signed [DW-1:0] mf_q,
  output logic signed [DW-1:0] dmf_i,
  output logic signed [DW-1:0] dmf_q,
  output logic signed [DW-1:0] ip_i,
  output logic signed [DW-1:0] ip_q
);
  localparam logic signed [XW-1:0] HALF = XW'(2 ** (SH - 1));
  localparam logic signed [XW-1:0] PMAX = XW'(2 ** (DW - 1) - 1);
  localparam logic signed [XW-1:0] NMIN = -PMAX - XW'(1);

  logic              vld;
  logic [FW-1:0]     frac_r;
  logic signed [ACCW-1:0] acc_all [4];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      frac_r <= '0;
    end else begin
      vld <= rd_en;
      if (clr) frac_r <= frac_in;
    end
  end

  // lane g: bit0 picks Q sample, bit1 picks derivative coefficient
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic signed [DW-1:0]   xs;
    logic signed [CW-1:0]   cs;
    logic signed [PWW-1:0]  prod;
    logic signed [ACCW-1:0] acc;

    assign xs   = (g % 2 == 0) ? xi : xq;
    assign cs   = (g < 2) ? ch : cd;
    assign prod = PWW'(xs) * PWW'(cs);

    always_ff @(posedge clk) begin
      if (rst)      acc <= '0;
      else if (clr) acc <= '0;
      else if (vld) acc <= acc + ACCW'(prod);
    end

    assign acc_all[g] = acc;
  end

  function automatic logic signed [DW-1:0] rsat(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] r;
    r = (v + HALF) >>> SH;
    if (r > PMAX)      r = PMAX;
    else if (r < NMIN) r = NMIN;
    return DW'(r);
  endfunction

  logic signed [FW:0]    fs;
  logic signed [SPW-1:0] sp_i, sp_q;
  logic signed [XW-1:0]  y_i, y_q;

  assign fs   = {1'b0, frac_r};
  assign sp_i = SPW'(acc_all[2]) * SPW'(fs);
  assign sp_q = SPW'(acc_all[3]) * SPW'(fs);
  assign y_i  = XW'(acc_all[0]) + XW'(sp_i >>> FW);
  assign y_q  = XW'(acc_all[1]) + XW'(sp_q >>> FW);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mf_i  <= '0;
      mf_q  <= '0;
      dmf_i <= '0;
      dmf_q <= '0;
      ip_i  <= '0;
      ip_q  <= '0;
    end else begin
      out_valid <= fin;
      if (fin) begin
        mf_i  <= rsat(XW'(acc_all[0]));
        mf_q  <= rsat(XW'(acc_all[1]));
        dmf_i <= rsat(XW'(acc_all[2]));
        dmf_q <= rsat(XW'(acc_all[3]));
        ip_i  <= rsat(y_i);
        ip_q  <= rsat(y_q);
      end
    end
  end
endmodule

// File: rtl/pfb_resampler.sv
module pfb_resampler #(
  parameter int NPHASE = 32,
  parameter int NTAP   = 39,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int ACCW   = 40,
  parameter int FW     = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 smp_we,
  input  logic signed [DW-1:0]                 smp_i,
  input  logic signed [DW-1:0]                 smp_q,
  input  logic                                 coef_we,
  input  logic [$clog2(NPHASE*NTAP)-1:0]       coef_addr,
  input  logic signed [CW-1:0]                 coef_h,
  input  logic signed [CW-1:0]                 coef_d,
  input  logic                                 req_valid,
  input  logic [$clog2(NPHASE)-1:0]            req_phase,
  input  logic [FW-1:0]                        req_frac,
  output logic                                 busy,
  output logic                                 out_valid,
  output logic signed [DW-1:0]                 mf_i,
  output logic signed [DW-1:0]                 mf_q,
  output logic signed [DW-1:0]                 dmf_i,
  output logic signed [DW-1:0]                 dmf_q,
  output logic signed [DW-1:0]                 ip_i,
  output logic signed [DW-1:0]                 ip_q
);
  localparam int NCOEF = NPHASE * NTAP;
  localparam int CAW   = $clog2(NCOEF);
  localparam int TW    = $clog2(NTAP);
  localparam int DLD   = 2 ** TW;
  localparam int DLPW  = $clog2(DLD);

  logic            accept, rd_en, fin;
  logic [TW-1:0]   tap;
  logic [CAW-1:0]  caddr;
  logic            dl_we, cb_we;
  logic [DLPW-1:0] dl_wptr;
  logic signed [DW-1:0] xi, xq;
  logic signed [CW-1:0] ch, cd;

  // stored state may only change between computations
  assign dl_we = smp_we  & ~busy;
  assign cb_we = coef_we & ~busy;

  pfb_ctrl #(.NPHASE(NPHASE), .NTAP(NTAP)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_phase(req_phase),
    .busy(busy), .accept(accept), .rd_en(rd_en), .tap(tap),
    .caddr(caddr), .fin(fin)
  );

  pfb_delay_line #(.DW(DW), .DEPTH(DLD), .TW(TW)) u_dline (
    .clk(clk), .rst(rst), .we(dl_we), .wi(smp_i), .wq(smp_q),
    .rd_en(rd_en), .age(tap), .rdi(xi), .rdq(xq), .wptr(dl_wptr)
  );

  pfb_coef_bank #(.CW(CW), .NCOEF(NCOEF)) u_coef (
    .clk(clk), .we(cb_we), .waddr(coef_addr), .wh(coef_h), .wd(coef_d),
    .rd_en(rd_en), .raddr(caddr), .rh(ch), .rd(cd)
  );

  pfb_mac #(.DW(DW), .CW(CW), .ACCW(ACCW), .FW(FW)) u_mac (
    .clk(clk), .rst(rst), .clr(accept), .frac_in(req_frac), .rd_en(rd_en),
    .xi(xi), .xq(xq), .ch(ch), .cd(cd), .fin(fin),
    .out_valid(out_valid), .mf_i(mf_i), .mf_q(mf_q),
    .dmf_i(dmf_i), .dmf_q(dmf_q), .ip_i(ip_i), .ip_q(ip_q)
  );
endmodule

// File: rtl/pfb_resampler_chk.sv
module pfb_resampler_chk #(
  parameter int NTAP = 39,
  parameter int PW   = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          out_valid,
  input logic          req_valid,
  input logic [PW-1:0] dl_wptr
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !out_valid));

  // R2
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: result follows exactly NTAP+2 busy cycles
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (bcnt == NTAP + 2));

  // R2
  a_r2_busy_ends_with_result: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> out_valid);

  // R2
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);

  // R8
  a_r8_line_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dl_wptr));
endmodule

bind pfb_resampler pfb_resampler_chk #(.NTAP(NTAP), .PW(DLPW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .out_valid(out_valid),
  .req_valid(req_valid), .dl_wptr(dl_wptr)
);

// File: tb/sim_pfb_resampler.sv
module sim_pfb_resampler;
  localparam int NPH = 32;
  localparam int NT  = 39;
  localparam int NC  = NPH * NT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_we = 1'b0, coef_we = 1'b0, req_valid = 1'b0;
  logic signed [15:0] smp_i = '0, smp_q = '0, coef_h = '0, coef_d = '0;
  logic [10:0] coef_addr = '0;
  logic [4:0]  req_phase = '0;
  logic [15:0] req_frac = '0;
  logic busy, out_valid;
  logic signed [15:0] mf_i, mf_q, dmf_i, dmf_q, ip_i, ip_q;

  int nchk = 0, nfail = 0, cyc = 0;
  int hc [NC];
  int dc [NC];
  int hist_i [$];
  int hist_q [$];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  pfb_resampler u0 (
    .clk(clk), .rst(rst), .smp_we(smp_we), .smp_i(smp_i), .smp_q(smp_q),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_h(coef_h), .coef_d(coef_d),
    .req_valid(req_valid), .req_phase(req_phase), .req_frac(req_frac),
    .busy(busy), .out_valid(out_valid), .mf_i(mf_i), .mf_q(mf_q),
    .dmf_i(dmf_i), .dmf_q(dmf_q), .ip_i(ip_i), .ip_q(ip_q)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog: actual %0d cycles expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  function automatic int rnd(int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % span) - span / 2;
  endfunction

  function automatic int rs(longint v);
    longint r = (v + 16384) >>> 15;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, nm, act, exp);
    end
  endtask

  task automatic wcoef(int a, int h, int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 11'(a); coef_h = 16'(h); coef_d = 16'(d);
    @(negedge clk);
    coef_we = 1'b0;
    hc[a] = h; dc[a] = d;
  endtask

  task automatic push(int i, int q);
    @(negedge clk);
    smp_we = 1'b1; smp_i = 16'(i); smp_q = 16'(q);
    @(negedge clk);
    smp_we = 1'b0;
    hist_i.push_front(i); hist_q.push_front(q);
  endtask

  // expected: {mf_i, mf_q, dmf_i, dmf_q, ip_i, ip_q}
  task automatic model(int p, int f, output int e [6]);
    longint ahi = 0, ahq = 0, adi = 0, adq = 0;
    for (int k = 0; k < NT; k++) begin
      ahi += longint'(hc[p*NT+k]) * hist_i[k];
      ahq += longint'(hc[p*NT+k]) * hist_q[k];
      adi += longint'(dc[p*NT+k]) * hist_i[k];
      adq += longint'(dc[p*NT+k]) * hist_q[k];
    end
    e[0] = rs(ahi); e[1] = rs(ahq); e[2] = rs(adi); e[3] = rs(adq);
    e[4] = rs(ahi + ((adi * longint'(f)) >>> 16));
    e[5] = rs(ahq + ((adq * longint'(f)) >>> 16));
  endtask

  task automatic cmp_out(string req, int e [6]);
    chk(req, "mf_i",  int'(mf_i),  e[0]);
    chk(req, "mf_q",  int'(mf_q),  e[1]);
    chk(req, "dmf_i", int'(dmf_i), e[2]);
    chk(req, "dmf_q", int'(dmf_q), e[3]);
    chk(req, "ip_i",  int'(ip_i),  e[4]);
    chk(req, "ip_q",  int'(ip_q),  e[5]);
  endtask

  task automatic wait_result(output int n);
    n = 0;
    while (!out_valid) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_req(int p, int f, string req);
    int e [6];
    int n;
    model(p, f, e);
    @(negedge clk);
    req_valid = 1'b1; req_phase = 5'(p); req_frac = 16'(f);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "busy after accept", int'(busy), 1);
    wait_result(n);
    chk("R2", "latency", n, NT + 2);
    chk("R2", "busy with result", int'(busy), 0);
    cmp_out(req, e);
    @(negedge clk);
    chk("R2", "pulse width", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "mf_i", int'(mf_i), 0);
    chk("R1", "ip_q", int'(ip_q), 0);
  endtask

  task automatic t_load();
    for (int a = 0; a < NC; a++) wcoef(a, rnd(4000), rnd(4000));
    for (int k = 0; k < 64; k++) push(0, 0);
  endtask

  // R3 R4 R6: single nonzero sample, distinct on I and Q
  task automatic t_impulse();
    push(8192, -4096);
    for (int k = 0; k < 5; k++) push(0, 0);
    run_req(3, 0, "R3 R4 R6 impulse");
    chk("R5", "ip_i equals mf_i at zero fraction", int'(ip_i), int'(mf_i));
  endtask

  // R3 R5 R11: several phases and fractions
  task automatic t_phases();
    for (int k = 0; k < NT; k++) push(rnd(16000), rnd(16000));
    run_req(0,  'h8000, "R3 R5 R11 phase0");
    run_req(17, 'hFFFF, "R3 R5 R11 phase17");
    run_req(31, 'h1234, "R3 R5 R11 phase31");
  endtask

  // R7 R8 R9: writes and request during a computation are dropped
  task automatic t_busy_ignore();
    int e [6];
    int n;
    int extra = 0;
    model(9, 'h4000, e);
    @(negedge clk);
    req_valid = 1'b1; req_phase = 5'd9; req_frac = 16'h4000;
    @(negedge clk);
    req_phase = 5'd2;
    smp_we = 1'b1; smp_i = 16'sd30000; smp_q = -16'sd30000;
    coef_we = 1'b1; coef_addr = 11'(9*NT); coef_h = 16'sd12345; coef_d = 16'sd12345;
    @(negedge clk);
    req_valid = 1'b0; smp_we = 1'b0; coef_we = 1'b0;
    wait_result(n);
    cmp_out("R8 R7 during busy", e);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    chk("R9", "extra result pulses", extra, 0);
    run_req(9, 'h4000, "R7 R8 state unchanged");
  endtask

  // R7: coefficient address layout phase*NT+tap
  task automatic t_layout();
    for (int k = 0; k < NT; k++) wcoef(20*NT + k, (k == 2) ? 16384 : 0, (k == 0) ? 32767 : 0);
    push(1000, -600); push(2000, 300); push(-3000, 700);
    run_req(20, 0, "R7 layout");
    chk("R7", "mf_i picks tap 2", int'(mf_i), 500);
    chk("R7", "dmf_q picks tap 0", int'(dmf_q), 700);
  endtask

  // R10: saturation in both directions
  task automatic t_saturate();
    for (int k = 0; k < NT; k++) wcoef(30*NT + k, 32767, -32768);
    for (int k = 0; k < NT; k++) push(30000, -30000);
    run_req(30, 'hFFFF, "R10 saturate");
    chk("R10", "mf_i max",  int'(mf_i),  32767);
    chk("R10", "mf_q min",  int'(mf_q),  -32768);
    chk("R10", "dmf_i min", int'(dmf_i), -32768);
    chk("R10", "dmf_q max", int'(dmf_q), 32767);
  endtask

  // R12: more writes than the delay line holds
  task automatic t_wrap();
    for (int k = 0; k < 100; k++) push(rnd(12000), rnd(12000));
    run_req(31, 'hA000, "R12 wrap");
    run_req(5,  'h0001, "R12 wrap");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_impulse();
    t_phases();
    t_busy_ignore();
    t_layout();
    t_saturate();
    t_wrap();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule